// File: doc/BRIEF.md
# Serial Configuration Frame Receiver

This block takes 12-bit configuration frames on a two-wire serial link and keeps one 8-bit setting register for each of two line-driver channels, A and B. The serial clock and data pins are brought into the system clock domain through a short synchronizer. Each frame is checked for correct framing and odd parity. A good frame carries a channel-select pair, a two-bit power-mode field and a four-bit bias code, and it writes them into channel A, channel B, both or neither.

For each channel the block decodes the stored setting into the digital controls of a driver: amplifier enable, boost-supply (charge pump) enable, line-termination enable and a bias level. A frame that fails any check is dropped and raises a sticky error flag. An active-low asynchronous reset forces both channels into power-down at once, abandons any partial frame and clears the flag.

Top module: `cfg_frame_rx`

## Requirements
- R1: `serData` is sampled on each rising edge of `serClk`, and the first bit taken is B0. While no frame is open, a sampled 1 is ignored as an idle line, and a sampled 0 opens a frame as B0.
- R2: A frame holds B0..B11. B2 and B3 select the channels, B4 is PD1, B5 is PD0, B6..B9 are the bias code, B10 is parity and B11 is the stop bit. A write stores, from register bit 7 down to bit 0: B2, B3, B4, B5, B6, B7, B8, B9.
- R3: B2=1 writes channel A (`chanReg[7:0]`, index 0 of the per-channel outputs). B3=1 writes channel B (`chanReg[15:8]`, index 1). Both set writes both channels with the same payload. Both clear leaves both registers unchanged.
- R4: Bits B2..B10 must hold an odd number of ones. Otherwise the frame is dropped and neither register changes.
- R5: B1 must be 1 and B11 must be 1. Otherwise the frame is dropped and neither register changes.
- R6: A dropped frame sets `frameErr`. The flag stays set through later valid frames and is cleared only by reset.
- R7: The power field {PD1,PD0} decodes as follows. 00: amplifier, pump and termination all off. 01: termination on, amplifier and pump off. 10: amplifier on, pump off. 11: amplifier and pump on. Termination is on only for 01.
- R8: The channel's `bias` output equals register bits 3..0, with B6 as the MSB, which gives levels 0..15.
- R9: A valid frame updates the registers exactly once, no more than SYNC_STAGES+3 system clocks after the rising `serClk` edge that carries B11. At all other times the registers and outputs hold.
- R10: While `rstN` is low, both registers are zero (power-down, bias 0), all enables are off and `frameErr` is clear. This takes effect without a clock edge, and any partial frame is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| serClk | input | 1 | Serial bit clock, idles low |
| serData | input | 1 | Serial data, idles high |
| chanReg | output | 16 | Setting registers, channel A in [7:0], B in [15:8] |
| ampEn | output | 2 | Amplifier enable per channel |
| pumpEn | output | 2 | Boost-supply enable per channel |
| termEn | output | 2 | Line-termination enable per channel |
| bias | output | 8 | Bias code per channel, A in [3:0] |
| frameErr | output | 1 | Sticky dropped-frame flag |

## Verification
The assertions check the following on every cycle: a register changes only in the cycle after its commit strobe; a written channel holds its own select bit; the pump is never on without the amplifier, and neither runs together with termination; the error flag only rises after a discard strobe and never falls outside reset. Only the bench's scenarios can show that a frame's exact payload lands in the right register: it sweeps every select, power and bias combination and checks the decoded outputs. The same holds for rejecting bad parity, start and stop bits, ignoring idle ones, and abandoning a frame cut by reset.

// File: rtl/cfg_frame_pkg.sv
package cfg_frame_pkg;
  localparam int FRAME_W  = 12;
  localparam int NUM_CH   = 2;
  localparam int BIAS_W   = 4;
  localparam int REG_W    = NUM_CH + 2 + BIAS_W;
  localparam int CNT_W    = $clog2(FRAME_W);
  // frame bit positions (arrival order, B0 first)
  localparam int POS_START0 = 0;
  localparam int POS_START1 = 1;
  localparam int POS_SEL    = 2;
  localparam int POS_PAR    = POS_SEL + REG_W;
  localparam int POS_STOP   = FRAME_W - 1;
  // register bit positions
  localparam int REG_PD1 = BIAS_W + 1;
  localparam int REG_PD0 = BIAS_W;

  typedef enum logic [1:0] {ST_IDLE, ST_RECV, ST_CHECK} rxState_t;

  typedef struct packed {
    logic              shiftEn;
    logic [NUM_CH-1:0] commit;
    logic              setErr;
  } rxStrobe_t;

  // register MSB holds the earliest payload bit (B2), LSB the last (B9)
  function automatic logic [REG_W-1:0] packReg(input logic [FRAME_W-1:0] f);
    logic [REG_W-1:0] r;
    for (int i = 0; i < REG_W; i++) r[REG_W-1-i] = f[POS_SEL+i];
    return r;
  endfunction
endpackage

// File: rtl/cfg_serial_sync.sv
module cfg_serial_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic serClk,
  input  logic serData,
  output logic bitStrobe,
  output logic bitVal
);
  logic [STAGES-1:0] clkSh;
  logic [STAGES-1:0] datSh;
  logic              clkPrev;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      clkSh   <= '0;
      datSh   <= '1;
      clkPrev <= 1'b0;
    end else begin
      clkSh[0] <= serClk;
      datSh[0] <= serData;
      for (int s = 1; s < STAGES; s++) begin
        clkSh[s] <= clkSh[s-1];
        datSh[s] <= datSh[s-1];
      end
      clkPrev <= clkSh[STAGES-1];
    end
  end

  assign bitStrobe = clkSh[STAGES-1] & ~clkPrev;
  assign bitVal    = datSh[STAGES-1];
endmodule

// File: rtl/cfg_frame_ctrl.sv
module cfg_frame_ctrl
  import cfg_frame_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               bitStrobe,
  input  logic               bitVal,
  input  logic [FRAME_W-1:0] frame,
  output rxStrobe_t          strobe
);
  localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(FRAME_W - 1);

  rxState_t         state, stateD;
  logic [CNT_W-1:0] cnt, cntD;
  logic             frameOk;

  assign frameOk = ~frame[POS_START0] & frame[POS_START1] & frame[POS_STOP]
                 & (^frame[POS_PAR:POS_SEL]);

  always_comb begin
    strobe = '0;
    stateD = state;
    cntD   = cnt;
    case (state)
      ST_IDLE: begin
        if (bitStrobe && !bitVal) begin
          strobe.shiftEn = 1'b1;
          cntD   = CNT_W'(1);
          stateD = ST_RECV;
        end
      end
      ST_RECV: begin
        if (bitStrobe) begin
          strobe.shiftEn = 1'b1;
          if (cnt == LAST_IDX) stateD = ST_CHECK;
          else                 cntD   = cnt + 1'b1;
        end
      end
      ST_CHECK: begin
        if (frameOk) strobe.commit = frame[POS_SEL +: NUM_CH];
        else         strobe.setErr = 1'b1;
        cntD   = '0;
        stateD = ST_IDLE;
      end
      default: begin
        cntD   = '0;
        stateD = ST_IDLE;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE;
      cnt   <= '0;
    end else begin
      state <= stateD;
      cnt   <= cntD;
    end
  end
endmodule

// File: rtl/cfg_frame_dp.sv
module cfg_frame_dp
  import cfg_frame_pkg::*;
(
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       bitVal,
  input  rxStrobe_t                  strobe,
  output logic [FRAME_W-1:0]         frame,
  output logic [NUM_CH*REG_W-1:0]    chanReg,
  output logic [NUM_CH-1:0]          ampEn,
  output logic [NUM_CH-1:0]          pumpEn,
  output logic [NUM_CH-1:0]          termEn,
  output logic [NUM_CH*BIAS_W-1:0]   bias,
  output logic                       frameErr
);
  logic [FRAME_W-1:0] frameQ;
  logic               errQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      frameQ <= '0;
      errQ   <= 1'b0;
    end else begin
      if (strobe.shiftEn) frameQ <= {bitVal, frameQ[FRAME_W-1:1]};
      if (strobe.setErr)  errQ   <= 1'b1;
    end
  end

  assign frame    = frameQ;
  assign frameErr = errQ;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic [REG_W-1:0] regQ;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                regQ <= '0;
      else if (strobe.commit[c]) regQ <= packReg(frameQ);
    end
    assign chanReg[c*REG_W +: REG_W]  = regQ;
    assign ampEn[c]                   = regQ[REG_PD1];
    assign pumpEn[c]                  = regQ[REG_PD1] & regQ[REG_PD0];
    assign termEn[c]                  = ~regQ[REG_PD1] & regQ[REG_PD0];
    assign bias[c*BIAS_W +: BIAS_W]   = regQ[BIAS_W-1:0];
  end
endmodule

// File: rtl/cfg_frame_rx.sv
module cfg_frame_rx
  import cfg_frame_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     serClk,
  input  logic                     serData,
  output logic [NUM_CH*REG_W-1:0]  chanReg,
  output logic [NUM_CH-1:0]        ampEn,
  output logic [NUM_CH-1:0]        pumpEn,
  output logic [NUM_CH-1:0]        termEn,
  output logic [NUM_CH*BIAS_W-1:0] bias,
  output logic                     frameErr
);
  logic               bitStrobe;
  logic               bitVal;
  logic [FRAME_W-1:0] frameQ;
  rxStrobe_t          ctlStrobe;

  cfg_serial_sync #(.STAGES(SYNC_STAGES)) i_sync (
    .clk(clk), .rstN(rstN), .serClk(serClk), .serData(serData),
    .bitStrobe(bitStrobe), .bitVal(bitVal)
  );

  cfg_frame_ctrl i_ctrl (
    .clk(clk), .rstN(rstN), .bitStrobe(bitStrobe), .bitVal(bitVal),
    .frame(frameQ), .strobe(ctlStrobe)
  );

  cfg_frame_dp i_dp (
    .clk(clk), .rstN(rstN), .bitVal(bitVal), .strobe(ctlStrobe),
    .frame(frameQ), .chanReg(chanReg), .ampEn(ampEn), .pumpEn(pumpEn),
    .termEn(termEn), .bias(bias), .frameErr(frameErr)
  );
endmodule

// File: rtl/cfg_frame_rx_chk.sv
module cfg_frame_rx_chk
  import cfg_frame_pkg::*;
(
  input logic                     clk,
  input logic                     rstN,
  input rxStrobe_t                ctlStrobe,
  input logic [NUM_CH*REG_W-1:0]  chanReg,
  input logic [NUM_CH-1:0]        ampEn,
  input logic [NUM_CH-1:0]        pumpEn,
  input logic [NUM_CH-1:0]        termEn,
  input logic [NUM_CH*BIAS_W-1:0] bias,
  input logic                     frameErr
);
  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    // R9: a register moves only right after its commit strobe
    p_reg_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
      !$past(ctlStrobe.commit[c]) |-> $stable(chanReg[c*REG_W +: REG_W]));
    // R8: bias follows only a commit
    p_bias_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
      !$past(ctlStrobe.commit[c]) |-> $stable(bias[c*BIAS_W +: BIAS_W]));
    // R3: a written channel carries its own select bit
    p_sel_bit_r3: assert property (@(posedge clk) disable iff (!rstN)
      $past(ctlStrobe.commit[c]) |-> chanReg[c*REG_W + REG_W - 1 - c]);
    // R7: pump needs amplifier; termination excludes both
    p_pump_amp_r7: assert property (@(posedge clk) disable iff (!rstN)
      pumpEn[c] |-> (ampEn[c] && !termEn[c]));
    p_term_alone_r7: assert property (@(posedge clk) disable iff (!rstN)
      termEn[c] |-> (!ampEn[c] && !pumpEn[c]));
  end

  // R6: error flag never drops outside reset
  p_err_sticky_r6: assert property (@(posedge clk) disable iff (!rstN)
    $past(frameErr) |-> frameErr);
  // R4: error flag rises only after a discard strobe
  p_err_source_r4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(frameErr) |-> $past(ctlStrobe.setErr));
  // R9: commit is a single-cycle event, never during a bit shift
  p_commit_once_r9: assert property (@(posedge clk) disable iff (!rstN)
    (|ctlStrobe.commit) |=> (ctlStrobe.commit == '0));
  p_commit_shift_r9: assert property (@(posedge clk) disable iff (!rstN)
    ctlStrobe.shiftEn |-> (ctlStrobe.commit == '0 && !ctlStrobe.setErr));
  // R10: during reset everything is powered down
  p_reset_off_r10: assert property (@(posedge clk)
    !rstN |-> (ampEn == '0 && pumpEn == '0 && termEn == '0 && !frameErr
               && chanReg == '0));
endmodule

bind cfg_frame_rx cfg_frame_rx_chk i_chk (
  .clk(clk), .rstN(rstN), .ctlStrobe(ctlStrobe), .chanReg(chanReg),
  .ampEn(ampEn), .pumpEn(pumpEn), .termEn(termEn), .bias(bias),
  .frameErr(frameErr)
);

// File: tb/test_cfg_frame_rx.sv
module test_cfg_frame_rx;
  logic        clk = 1'b0;
  logic        rstN = 1'b1;
  logic        serClk = 1'b0;
  logic        serData = 1'b1;
  logic [15:0] chanReg;
  logic [1:0]  ampEn, pumpEn, termEn;
  logic [7:0]  bias;
  logic        frameErr;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  logic [7:0] model [2];
  logic       modelErr;

  always #2.5 clk = ~clk;

  cfg_frame_rx i_cfg_frame_rx (
    .clk(clk), .rstN(rstN), .serClk(serClk), .serData(serData),
    .chanReg(chanReg), .ampEn(ampEn), .pumpEn(pumpEn), .termEn(termEn),
    .bias(bias), .frameErr(frameErr)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  // compare every output against the bench model
  task automatic checkAll(input string req);
    for (int c = 0; c < 2; c++) begin
      chk({req, " reg R2"},  chanReg[c*8 +: 8], model[c]);
      chk({req, " amp R7"},  ampEn[c],  model[c][5]);
      chk({req, " pump R7"}, pumpEn[c], model[c][5] & model[c][4]);
      chk({req, " term R7"}, termEn[c], ~model[c][5] & model[c][4]);
      chk({req, " bias R8"}, bias[c*4 +: 4], model[c][3:0]);
    end
    chk({req, " err R6"}, frameErr, modelErr);
  endtask

  // payload p: p[7]=B2, p[6]=B3, p[5]=B4, p[4]=B5, p[3:0]=B6..B9 (B6 MSB)
  function automatic logic [11:0] mkFrame(input logic [7:0] p);
    logic [11:0] f;
    f[0] = 1'b0;
    f[1] = 1'b1;
    for (int i = 0; i < 8; i++) f[2+i] = p[7-i];
    f[10] = ~(^f[9:2]);
    f[11] = 1'b1;
    return f;
  endfunction

  task automatic sendBit(input logic b);
    serData = b;
    #20 serClk = 1'b1;
    #20 serClk = 1'b0;
  endtask

  task automatic sendFrame(input logic [11:0] f);
    for (int i = 0; i < 12; i++) sendBit(f[i]);
    serData = 1'b1;
    #75;
  endtask

  task automatic applyValid(input logic [7:0] p);
    sendFrame(mkFrame(p));
    if (p[7]) model[0] = p;
    if (p[6]) model[1] = p;
  endtask

  task automatic doReset();
    rstN = 1'b0;
    #1;
    model[0] = '0; model[1] = '0; modelErr = 1'b0;
    checkAll("reset immediate R10");
    #19 rstN = 1'b1;
    #20;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [11:0] f;
    model[0] = '0; model[1] = '0; modelErr = 1'b0;
    #1 doReset();
    checkAll("reset state R10");

    // R3/R2/R7/R8/R9: every select, power and bias combination, both-channel first
    for (int code = 255; code >= 0; code--) begin
      applyValid(8'(code));
      checkAll("sweep R3 R9");
    end

    // R1: idle ones are ignored, then a frame is still taken
    for (int i = 0; i < 5; i++) sendBit(1'b1);
    #75;
    checkAll("idle ones R1");
    applyValid(8'hDB);
    checkAll("frame after idle R1");

    // R4: bad parity dropped
    f = mkFrame(8'hA5); f[10] = ~f[10];
    sendFrame(f); modelErr = 1'b1;
    checkAll("bad parity R4");
    // R6: valid frame still commits, flag stays
    applyValid(8'h7E);
    checkAll("sticky flag R6");

    doReset();
    // R5: bad second start bit
    f = mkFrame(8'hF3); f[1] = 1'b0;
    sendFrame(f); modelErr = 1'b1;
    checkAll("bad start R5");

    doReset();
    // R5: bad stop bit
    f = mkFrame(8'hE6); f[11] = 1'b0;
    sendFrame(f); modelErr = 1'b1;
    checkAll("bad stop R5");

    doReset();
    applyValid(8'hF9);
    checkAll("preload R10");
    // R10: reset in the middle of a frame
    f = mkFrame(8'h8C);
    for (int i = 0; i < 6; i++) sendBit(f[i]);
    doReset();
    checkAll("after cut R10");
    applyValid(8'h5A);
    checkAll("frame after cut R10");

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule